// File: doc/BRIEF.md
# Iterative Integer Multiplier with Low and High Product Halves

This block multiplies two 32-bit register operands and returns one 32-bit half of the 64-bit product. A 3-bit operation code picks the variant. Code 0 returns the low word. Codes 1, 2 and 3 return the high word, with different operand signedness: both signed, first signed and second unsigned, or both unsigned. An issuing pipeline presents the operands, the code and a destination register index together with a one-cycle start strobe. Exactly one completion pulse comes back after a fixed latency. The pulse carries the result, the index and a write-enable for the register file.

Internally each operand is turned into an unsigned magnitude, and the sign of the product is recorded. The unsigned product is built one digit of the second operand per cycle, with `DIGIT` bits per digit, by shift-and-add. At the end the sum is negated if the sign requires it, and the wanted half is selected. A state machine has three states:
- **IDLE** waits for a start.
- **CALC** accumulates one digit per cycle.
- **DONE** presents the result for one cycle.

Its transitions are:
- IDLE→CALC on an accepted start.
- CALC→CALC while digits remain.
- CALC→DONE on the last digit.
- DONE→IDLE unconditionally.
- Any state→IDLE on reset.

Top module: `imul_unit`

## Requirements
- R1: Code 3'b000 returns bits [31:0] of the product of the two operands.
- R2: Code 3'b001 treats both operands as two's-complement signed and returns bits [63:32] of their 64-bit product.
- R3: Code 3'b010 treats the first operand as signed and the second as unsigned, and returns bits [63:32] of the product.
- R4: Code 3'b011 treats both operands as unsigned and returns bits [63:32] of the product.
- R5: `done_o` is a single-cycle pulse. It is high in the cycle after the LATENCY-th rising edge, counting the edge that samples the accepted start as the first. LATENCY = XLEN/DIGIT + 1, which is 5 with the defaults.
- R6: With `done_o`, `rd_o` carries the destination index latched at start. `wr_en_o` is high exactly when `done_o` is high and that index is nonzero.
- R7: `busy_o` is high from the cycle after an accepted start through the done cycle. A start seen while `busy_o` is high, including in the done cycle, is ignored: the result and index of the running operation are unchanged, and no extra completion follows.
- R8: A start whose code has bit 2 set is ignored: `busy_o` stays low and no completion follows.
- R9: A synchronous active-high reset returns the block to IDLE, clearing `busy_o` and `done_o` and abandoning any operation in progress.
- R10: While `done_o` is low, `result_o` and `rd_o` are zero and `wr_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe |
| op_i | input | 3 | Operation code (bit 2 set = not a multiply) |
| rs1_val_i | input | 32 | First operand |
| rs2_val_i | input | 32 | Second operand |
| rd_i | input | 5 | Destination register index |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| result_o | output | 32 | Selected product half |
| rd_o | output | 5 | Destination index for the result |
| wr_en_o | output | 1 | Register write enable |

## Verification
A new start can coincide with the done pulse of the running operation, or arrive while an operation is still accumulating. The bench raises start, with different operands and a different index, once in mid-computation and once exactly in the done cycle. It then requires three things:
- the running operation's result and index are unaffected;
- `busy_o` falls after the done cycle;
- no second completion appears within a full latency window.

Reset asserted mid-computation is judged the same way: nothing completes afterwards.

// File: rtl/imul_pkg.sv
package imul_pkg;

    typedef enum logic [1:0] {
        OP_LO  = 2'b00,
        OP_HSS = 2'b01,
        OP_HSU = 2'b10,
        OP_HUU = 2'b11
    } mul_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_CALC = 2'b01,
        ST_DONE = 2'b10
    } mul_state_e;

endpackage

// File: rtl/imul_prep.sv
module imul_prep
    import imul_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  mul_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  a_mag,
    output logic [XLEN-1:0]  b_mag,
    output logic             neg
);
    logic a_signed, b_signed, a_neg, b_neg;

    always_comb begin
        a_signed = (op == OP_HSS) || (op == OP_HSU);
        b_signed = (op == OP_HSS);
        a_neg    = a_signed & a[XLEN-1];
        b_neg    = b_signed & b[XLEN-1];
        a_mag    = a_neg ? (~a + XLEN'(1)) : a;
        b_mag    = b_neg ? (~b + XLEN'(1)) : b;
        neg      = a_neg ^ b_neg;
    end
endmodule

// File: rtl/imul_core.sv
module imul_core #(
    parameter int XLEN  = 32,
    parameter int DIGIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [XLEN-1:0]   a_mag,
    input  logic [XLEN-1:0]   b_mag,
    output logic [2*XLEN-1:0] prod
);
    localparam int PW = 2 * XLEN;

    logic [PW-1:0]   a_sh;
    logic [XLEN-1:0] b_sh;
    logic [PW-1:0]   acc;
    logic [PW-1:0]   partial;

    generate
        if (DIGIT == 1) begin : g_bitwise
            always_comb partial = b_sh[0] ? a_sh : '0;
        end else begin : g_digit
            always_comb partial = a_sh * {{(PW-DIGIT){1'b0}}, b_sh[DIGIT-1:0]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            a_sh <= '0;
            b_sh <= '0;
            acc  <= '0;
        end else if (load) begin
            a_sh <= {{XLEN{1'b0}}, a_mag};
            b_sh <= b_mag;
            acc  <= '0;
        end else if (step) begin
            acc  <= acc + partial;
            a_sh <= a_sh << DIGIT;
            b_sh <= b_sh >> DIGIT;
        end
    end

    assign prod = acc;
endmodule

// File: rtl/imul_finish.sv
module imul_finish #(
    parameter int XLEN = 32
) (
    input  logic [2*XLEN-1:0] prod,
    input  logic              neg,
    input  logic              hi,
    output logic [XLEN-1:0]   res
);
    logic [2*XLEN-1:0] signed_prod;

    always_comb begin
        signed_prod = neg ? (~prod + (2*XLEN)'(1)) : prod;
        res         = hi ? signed_prod[2*XLEN-1:XLEN] : signed_prod[XLEN-1:0];
    end
endmodule

// File: rtl/imul_unit.sv
module imul_unit
    import imul_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int DIGIT = 8,
    parameter int RIDX  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [2:0]      op_i,
    input  logic [XLEN-1:0] rs1_val_i,
    input  logic [XLEN-1:0] rs2_val_i,
    input  logic [RIDX-1:0] rd_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o,
    output logic [RIDX-1:0] rd_o,
    output logic            wr_en_o
);
    localparam int STEPS   = XLEN / DIGIT;
    localparam int CW      = $clog2(STEPS) + 1;
    localparam int LATENCY = STEPS + 1;

    mul_state_e      state, state_nx;
    logic [CW-1:0]   cnt;
    mul_op_e         op_q;
    logic            neg_q;
    logic [RIDX-1:0] rd_q;

    logic            accept;
    logic            last_digit;
    mul_op_e         op_in;
    logic [XLEN-1:0] a_mag, b_mag;
    logic            neg_in;
    logic [2*XLEN-1:0] prod;
    logic [XLEN-1:0] res;

    assign op_in      = mul_op_e'(op_i[1:0]);
    assign accept     = start_i && (state == ST_IDLE) && !op_i[2];
    assign last_digit = (cnt == CW'(STEPS - 1));

    imul_prep #(.XLEN(XLEN)) u_prep (
        .op    (op_in),
        .a     (rs1_val_i),
        .b     (rs2_val_i),
        .a_mag (a_mag),
        .b_mag (b_mag),
        .neg   (neg_in)
    );

    imul_core #(.XLEN(XLEN), .DIGIT(DIGIT)) u_core (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .step  (state == ST_CALC),
        .a_mag (a_mag),
        .b_mag (b_mag),
        .prod  (prod)
    );

    imul_finish #(.XLEN(XLEN)) u_finish (
        .prod (prod),
        .neg  (neg_q),
        .hi   (op_q != OP_LO),
        .res  (res)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)     state_nx = ST_CALC;
            ST_CALC: if (last_digit) state_nx = ST_DONE;
            ST_DONE:                 state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    // operation context and digit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            op_q  <= OP_LO;
            neg_q <= 1'b0;
            rd_q  <= '0;
        end else if (accept) begin
            cnt   <= '0;
            op_q  <= op_in;
            neg_q <= neg_in;
            rd_q  <= rd_i;
        end else if (state == ST_CALC) begin
            cnt   <= cnt + CW'(1);
        end
    end

    // outputs
    always_comb begin
        busy_o   = 1'b0;
        done_o   = 1'b0;
        result_o = '0;
        rd_o     = '0;
        wr_en_o  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_CALC: busy_o = 1'b1;
            ST_DONE: begin
                busy_o   = 1'b1;
                done_o   = 1'b1;
                result_o = res;
                rd_o     = rd_q;
                wr_en_o  = (rd_q != '0);
            end
            default: ;
        endcase
    end

    initial begin
        if (XLEN % DIGIT != 0) $error("DIGIT must divide XLEN");
        if (LATENCY < 2)       $error("latency below two cycles");
    end
endmodule

// File: rtl/imul_unit_chk.sv
module imul_unit_chk #(
    parameter int XLEN  = 32,
    parameter int DIGIT = 8,
    parameter int RIDX  = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic [2:0]      op_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [XLEN-1:0] result_o,
    input logic [RIDX-1:0] rd_o,
    input logic            wr_en_o
);
    localparam int LATENCY = XLEN / DIGIT + 1;
    localparam int LW      = $clog2(LATENCY + 1) + 1;

    logic [LW-1:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst)                                   lat_cnt <= '0;
        else if (start_i && !busy_o && !op_i[2])   lat_cnt <= LW'(1);
        else if (done_o)                           lat_cnt <= '0;
        else if (lat_cnt != '0)                    lat_cnt <= lat_cnt + LW'(1);
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_fixed_latency_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (lat_cnt == LW'(LATENCY)));

    assert_wren_needs_done_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (done_o && rd_o != '0));

    assert_wren_on_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && rd_o != '0) |-> wr_en_o);

    assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !op_i[2]) |=> busy_o);

    assert_bad_code_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && op_i[2]) |=> !busy_o);

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o));

    assert_quiet_outputs_R10: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (result_o == '0 && rd_o == '0 && !wr_en_o));
endmodule

bind imul_unit imul_unit_chk #(.XLEN(XLEN), .DIGIT(DIGIT), .RIDX(RIDX)) u_chk (.*);

// File: tb/imul_unit_test.sv
module imul_unit_test;
    localparam int LAT  = 32 / 8 + 1;
    localparam int NVEC = 12;

    localparam logic [66:0] VEC [NVEC] = '{
        {3'd0, 32'h0000_0007, 32'h0000_0006},
        {3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {3'd0, 32'h1234_5678, 32'h9ABC_DEF0},
        {3'd1, 32'h8000_0000, 32'h8000_0000},
        {3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {3'd1, 32'h7FFF_FFFF, 32'h8000_0000},
        {3'd1, 32'h1234_5678, 32'hFEDC_BA98},
        {3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {3'd2, 32'h8000_0000, 32'hFFFF_FFFF},
        {3'd2, 32'h1234_5678, 32'h9ABC_DEF0},
        {3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {3'd3, 32'h8000_0000, 32'h0000_0002}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  op;
    logic [31:0] rs1, rs2;
    logic [4:0]  rd;
    logic        busy, done, wr_en;
    logic [31:0] result;
    logic [4:0]  rd_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    imul_unit uut (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .op_i      (op),
        .rs1_val_i (rs1),
        .rs2_val_i (rs2),
        .rd_i      (rd),
        .busy_o    (busy),
        .done_o    (done),
        .result_o  (result),
        .rd_o      (rd_out),
        .wr_en_o   (wr_en)
    );

    function automatic logic [31:0] model(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] ea, eb, p;
        ea = (c == 3'd1 || c == 3'd2) ? {{32{a[31]}}, a} : {32'b0, a};
        eb = (c == 3'd1) ? {{32{b[31]}}, b} : {32'b0, b};
        p  = ea * eb;
        return (c == 3'd0) ? p[31:0] : p[63:32];
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd0:    return "R1";
            3'd1:    return "R2";
            3'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic expect_silence(input string what);
        int seen = 0;
        for (int k = 0; k < LAT + 2; k++) begin
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            if (done) seen++;
        end
        chk(what, 32'(seen), 32'd0);
    endtask

    // inject: 0 none, 1 start during accumulation, 2 start in the done cycle
    task automatic run_op(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                          input logic [4:0] d, input int inject);
        logic [31:0] exp;
        string       tg;
        exp = model(c, a, b);
        tg  = tag_of(c);
        @(negedge clk);
        start = 1'b1; op = c; rs1 = a; rs2 = b; rd = d;
        for (int i = 1; i <= LAT; i++) begin
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            if (i == 1) chk("R7 busy after start", 32'(busy), 32'd1);
            if (i < LAT) begin
                chk("R5 done early", 32'(done), 32'd0);
                if (inject == 1 && i == 2) begin
                    start = 1'b1; op = 3'd3; rs1 = 32'hFFFF_FFFF; rs2 = 32'h1; rd = 5'd9;
                end
            end else begin
                chk("R5 done on time", 32'(done), 32'd1);
                chk({tg, " result"}, result, exp);
                chk("R6 index", 32'(rd_out), 32'(d));
                chk("R6 write enable", 32'(wr_en), 32'(d != 5'd0));
                if (inject == 2) begin
                    start = 1'b1; op = 3'd0; rs1 = 32'h5; rs2 = 32'h5; rd = 5'd3;
                end
            end
        end
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        chk("R5 single pulse", 32'(done), 32'd0);
        chk("R7 idle after done", 32'(busy), 32'd0);
        chk("R10 quiet result", result, 32'd0);
        if (inject != 0) expect_silence("R7 ignored start");
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; op = '0; rs1 = '0; rs2 = '0; rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 busy in reset", 32'(busy), 32'd0);
        chk("R9 done in reset", 32'(done), 32'd0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R10 idle result", result, 32'd0);
        chk("R10 idle wr_en", 32'(wr_en), 32'd0);

        for (int v = 0; v < NVEC; v++)
            run_op(VEC[v][66:64], VEC[v][63:32], VEC[v][31:0], 5'(v + 1), 0);

        // R6: destination zero suppresses the write
        run_op(3'd0, 32'd9, 32'd9, 5'd0, 0);

        // R7: start during accumulation and in the done cycle
        run_op(3'd1, 32'hDEAD_BEEF, 32'h0BAD_F00D, 5'd17, 1);
        run_op(3'd2, 32'hC000_0001, 32'h7FFF_FFFF, 5'd31, 2);

        // R8: code with bit 2 set is ignored
        @(negedge clk);
        start = 1'b1; op = 3'b100; rs1 = 32'd3; rs2 = 32'd4; rd = 5'd2;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        chk("R8 no busy", 32'(busy), 32'd0);
        expect_silence("R8 no completion");

        // R9: reset mid-operation abandons it
        @(negedge clk);
        start = 1'b1; op = 3'd3; rs1 = 32'hFFFF_0000; rs2 = 32'h0000_FFFF; rd = 5'd4;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        @(posedge clk); @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R9 busy cleared", 32'(busy), 32'd0);
        chk("R9 done cleared", 32'(done), 32'd0);
        expect_silence("R9 no completion after reset");

        run_op(3'd3, 32'hFFFF_0000, 32'h0000_FFFF, 5'd4, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule